// File: doc/BRIEF.md
# Video Pixel Output Formatter

This block sits behind a video link deserializer and presents decoded pixels on a parallel output port. Each pixel has 18 bits of colour (6 red, 6 green, 6 blue) and carries horizontal sync, vertical sync and a 4-bit control field. The block also generates a shift clock so that a panel-side device can capture the output words. It has two packing modes. In one-pixel mode every pixel becomes one output word. In two-pixel mode two consecutive pixels are packed onto two output buses and leave together as one word, at half the word rate.

Pixels enter through a valid/ready handshake. The shift clock period, in system clock cycles, comes from the panel-size selection and doubles in two-pixel mode. The shift clock pulses once for each word that leaves the block, and its polarity is selectable. Test strapping can drive every output to a constant level. An unsupported panel code is flagged, and the outputs then rest high. A loss-of-signal output follows the upstream link indication. The configuration pins are taken in only while the block is in reset or the link is down, so a mode can never change in the middle of a line.

Top module: `pxo_out`

## Requirements
- R1: While `rst_n` is low, `los_o` is 1, `in_ready` is 0 and `bus1_rgb` is 0. `sclk_o` rests at its capture level: 1 when test code 00 is in force.
- R2: In one-pixel mode (`cfg_one_pix`=1), each accepted pixel appears on `bus1_rgb`, `hs_o`, `vs_o` and `ctl_o` on the clock edge that accepts it, and `bus0_rgb` reads all ones.
- R3: In two-pixel mode (`cfg_one_pix`=0), accepting the first pixel of a pair leaves all outputs unchanged. The edge that accepts the second pixel puts the first pixel on `bus0_rgb` and the second on `bus1_rgb`; sync and control come from the first pixel.
- R4: The shift clock period P is 8, 5 or 3 system cycles for panel codes 00, 01 and 10, and twice that in two-pixel mode. After a word leaves, the next word cannot leave for P cycles: in one-pixel mode `in_ready` is low for P-1 cycles and high again in the cycle P-1 after the emit.
- R5: After each emitted word, `sclk_o` holds the launch level for floor(P/2) cycles and then the capture level until the next word. Test code 00 means launch 0 and capture 1 (data taken on the rising edge); code 01 inverts both levels.
- R6: Test code 10 drives `sclk_o`, both buses, `hs_o`, `vs_o`, `ctl_o` and `los_o` all low. Code 11 drives them all high. In both cases `in_ready` is 0 and `panel_err` is not forced.
- R7: Panel code 11 sets `panel_err` to 1, drives every forced output high whatever the test code, and holds `in_ready` at 0.
- R8: `los_o` equals the inverse of `link_up` one clock later, and `in_ready` is 0 in every cycle that follows a cycle with `link_up` low.
- R9: A link drop discards a pending first pixel of a pair, so the next accepted pixel starts a new pair.
- R10: The configuration inputs are loaded only on edges where `rst_n` or `link_up` is low. Changes made while the link is up have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is loaded during it |
| link_up | input | 1 | Upstream link activity; low means disconnected or idle |
| cfg_one_pix | input | 1 | 1 = one pixel per word, 0 = two pixels per word |
| cfg_panel | input | 2 | Panel size code: 00 small, 01 medium, 10 large, 11 unsupported |
| cfg_test | input | 2 | 00 rising capture, 01 falling capture, 10 force low, 11 force high |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted on this edge when valid |
| in_rgb | input | 18 | Input colour: red [17:12], green [11:6], blue [5:0] |
| in_hs | input | 1 | Input horizontal sync |
| in_vs | input | 1 | Input vertical sync |
| in_ctl | input | 4 | Input control field |
| sclk_o | output | 1 | Generated shift clock |
| bus0_rgb | output | 18 | First pixel of a pair; all ones in one-pixel mode |
| bus1_rgb | output | 18 | Second pixel of a pair, or the single pixel |
| hs_o | output | 1 | Output horizontal sync |
| vs_o | output | 1 | Output vertical sync |
| ctl_o | output | 4 | Output control field |
| los_o | output | 1 | Loss of signal |
| panel_err | output | 1 | Unsupported panel code loaded |

## Verification
A pairing flag left set shows at the ports within one word: the wrong pixel appears on `bus0_rgb`, or a word is emitted one pixel early. A period or phase counter that is off by one shows in the first shift clock period after an emit, either as `sclk_o` changing level a cycle late or as `in_ready` returning a cycle early or late. A configuration register that loads while the link is up shows in the next emitted word as the wrong bus fill or the wrong clock polarity. The bench therefore sweeps every supported panel and polarity in both packing modes and samples every cycle of every word.

// File: rtl/pxo_pkg.sv
`timescale 1ns/1ps
package pxo_pkg;
    localparam int COLOR_W = 6;
    localparam int PIX_W   = 3 * COLOR_W;
    localparam int CTL_W   = 4;

    typedef logic [PIX_W-1:0] rgb_t;

    typedef struct packed {
        logic             hs;
        logic             vs;
        logic [CTL_W-1:0] ctl;
    } side_t;

    typedef struct packed {
        rgb_t  rgb;
        side_t side;
    } pix_t;

    typedef enum logic [1:0] {
        TST_RISE = 2'b00,
        TST_FALL = 2'b01,
        TST_LOW  = 2'b10,
        TST_HIGH = 2'b11
    } tst_e;

    typedef enum logic [1:0] {
        PNL_SMALL = 2'b00,
        PNL_MID   = 2'b01,
        PNL_LARGE = 2'b10,
        PNL_NONE  = 2'b11
    } pnl_e;
endpackage

// File: rtl/pxo_cfg.sv
`timescale 1ns/1ps
// Configuration capture and loss-of-signal register.
module pxo_cfg
    import pxo_pkg::*;
#(
    parameter int P_SMALL = 8,
    parameter int P_MID   = 5,
    parameter int P_LARGE = 3,
    parameter int CNT_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             link_up,
    input  logic             one_pix_i,
    input  logic [1:0]       panel_i,
    input  logic [1:0]       test_i,
    output logic             los_o,
    output logic             one_o,
    output logic             bad_o,
    output logic             frc_o,
    output logic             lvl_o,
    output logic             fall_o,
    output logic [CNT_W-1:0] per_o
);
    typedef struct packed {
        logic             los;
        logic             one;
        logic             bad;
        tst_e             test;
        logic [CNT_W-1:0] per;
    } cfg_st_t;

    cfg_st_t st_d, st_q;
    logic [CNT_W-1:0] base;

    always_comb begin
        unique case (pnl_e'(panel_i))
            PNL_MID:   base = CNT_W'(P_MID);
            PNL_LARGE: base = CNT_W'(P_LARGE);
            default:   base = CNT_W'(P_SMALL);
        endcase

        st_d     = st_q;
        st_d.los = !rst_n || !link_up;
        // load window: reset or link down only
        if (!rst_n || !link_up) begin
            st_d.one  = one_pix_i;
            st_d.bad  = (pnl_e'(panel_i) == PNL_NONE);
            st_d.test = tst_e'(test_i);
            st_d.per  = one_pix_i ? base : (base << 1);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign los_o  = st_q.los;
    assign one_o  = st_q.one;
    assign bad_o  = st_q.bad;
    assign per_o  = st_q.per;
    assign fall_o = (st_q.test == TST_FALL);
    assign frc_o  = st_q.bad || (st_q.test == TST_LOW) || (st_q.test == TST_HIGH);
    // an unsupported panel wins over a force-low strap
    assign lvl_o  = st_q.bad || (st_q.test != TST_LOW);
endmodule

// File: rtl/pxo_pair.sv
`timescale 1ns/1ps
// Input handshake, pair assembly and output word registers.
module pxo_pair
    import pxo_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  blk,
    input  logic  one,
    input  logic  free,
    input  logic  in_valid,
    input  pix_t  in_pix,
    output logic  in_ready,
    output logic  emit,
    output logic  hf,
    output rgb_t  b0,
    output rgb_t  b1,
    output side_t side
);
    typedef struct packed {
        logic  hf;
        pix_t  first;
        rgb_t  b0;
        rgb_t  b1;
        side_t side;
    } pair_st_t;

    localparam pair_st_t RST = '0;

    pair_st_t st_d, st_q;
    logic     acc;

    always_comb begin
        st_d     = st_q;
        emit     = 1'b0;
        // a first pixel may be parked while the timer still runs
        in_ready = !blk && (free || (!one && !st_q.hf));
        acc      = in_valid && in_ready;

        if (blk) begin
            st_d.hf = 1'b0;
        end else if (acc) begin
            if (one) begin
                st_d.b1   = in_pix.rgb;
                st_d.side = in_pix.side;
                emit      = 1'b1;
            end else if (!st_q.hf) begin
                st_d.first = in_pix;
                st_d.hf    = 1'b1;
            end else begin
                st_d.b0   = st_q.first.rgb;
                st_d.b1   = in_pix.rgb;
                st_d.side = st_q.first.side;
                st_d.hf   = 1'b0;
                emit      = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RST;
        else        st_q <= st_d;
    end

    assign hf   = st_q.hf;
    assign b0   = st_q.b0;
    assign b1   = st_q.b1;
    assign side = st_q.side;
endmodule

// File: rtl/pxo_sclk.sv
`timescale 1ns/1ps
// Word period timer and shift clock phase.
module pxo_sclk #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             blk,
    input  logic             emit,
    input  logic [CNT_W-1:0] per,
    output logic             free,
    output logic             ph
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ph;
    } tmr_st_t;

    localparam tmr_st_t RST = '{cnt: '0, ph: 1'b1};

    tmr_st_t st_d, st_q;
    logic [CNT_W-1:0] half;

    always_comb begin
        half = per >> 1;
        st_d = st_q;
        if (blk) begin
            st_d.cnt = '0;
            st_d.ph  = 1'b1;
        end else if (emit) begin
            st_d.cnt = per - CNT_W'(1);
            st_d.ph  = 1'b0;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
            // capture phase once floor(per/2) launch cycles are spent
            st_d.ph  = (st_d.cnt < (per - half));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RST;
        else        st_q <= st_d;
    end

    assign free = (st_q.cnt == '0);
    assign ph   = st_q.ph;
endmodule

// File: rtl/pxo_out.sv
`timescale 1ns/1ps
// Video pixel output formatter, top level.
module pxo_out
    import pxo_pkg::*;
#(
    parameter int P_SMALL = 8,
    parameter int P_MID   = 5,
    parameter int P_LARGE = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             link_up,
    input  logic             cfg_one_pix,
    input  logic [1:0]       cfg_panel,
    input  logic [1:0]       cfg_test,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [PIX_W-1:0] in_rgb,
    input  logic             in_hs,
    input  logic             in_vs,
    input  logic [CTL_W-1:0] in_ctl,
    output logic             sclk_o,
    output logic [PIX_W-1:0] bus0_rgb,
    output logic [PIX_W-1:0] bus1_rgb,
    output logic             hs_o,
    output logic             vs_o,
    output logic [CTL_W-1:0] ctl_o,
    output logic             los_o,
    output logic             panel_err
);
    localparam int P_MAX1 = (P_SMALL > P_MID) ? P_SMALL : P_MID;
    localparam int P_MAX  = (P_MAX1 > P_LARGE) ? P_MAX1 : P_LARGE;
    localparam int CNT_W  = $clog2(2 * P_MAX + 1);

    logic             los_q, one_q, bad_q, frc_q, lvl_q, fall_q;
    logic [CNT_W-1:0] per_q;
    logic             blk, emit, free, ph, hf_q;
    rgb_t             b0, b1;
    side_t            side;
    pix_t             in_pix;

    assign in_pix = '{rgb: in_rgb, side: '{hs: in_hs, vs: in_vs, ctl: in_ctl}};
    assign blk    = los_q || frc_q;

    pxo_cfg #(
        .P_SMALL(P_SMALL), .P_MID(P_MID), .P_LARGE(P_LARGE), .CNT_W(CNT_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .link_up(link_up),
        .one_pix_i(cfg_one_pix), .panel_i(cfg_panel), .test_i(cfg_test),
        .los_o(los_q), .one_o(one_q), .bad_o(bad_q), .frc_o(frc_q),
        .lvl_o(lvl_q), .fall_o(fall_q), .per_o(per_q)
    );

    pxo_pair u_pair (
        .clk(clk), .rst_n(rst_n), .blk(blk), .one(one_q), .free(free),
        .in_valid(in_valid), .in_pix(in_pix), .in_ready(in_ready),
        .emit(emit), .hf(hf_q), .b0(b0), .b1(b1), .side(side)
    );

    pxo_sclk #(.CNT_W(CNT_W)) u_sclk (
        .clk(clk), .rst_n(rst_n), .blk(blk), .emit(emit), .per(per_q),
        .free(free), .ph(ph)
    );

    always_comb begin
        if (frc_q) begin
            sclk_o   = lvl_q;
            bus0_rgb = {PIX_W{lvl_q}};
            bus1_rgb = {PIX_W{lvl_q}};
            hs_o     = lvl_q;
            vs_o     = lvl_q;
            ctl_o    = {CTL_W{lvl_q}};
            los_o    = lvl_q;
        end else begin
            sclk_o   = ph ^ fall_q;
            bus0_rgb = one_q ? {PIX_W{1'b1}} : b0;
            bus1_rgb = b1;
            hs_o     = side.hs;
            vs_o     = side.vs;
            ctl_o    = side.ctl;
            los_o    = los_q;
        end
    end

    assign panel_err = bad_q;
endmodule

// File: rtl/pxo_out_chk.sv
`timescale 1ns/1ps
module pxo_out_chk
    import pxo_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             link_up,
    input logic             in_valid,
    input logic             in_ready,
    input logic [PIX_W-1:0] bus0_rgb,
    input logic [PIX_W-1:0] bus1_rgb,
    input logic             sclk_o,
    input logic             los_o,
    input logic             panel_err,
    input logic             one_q,
    input logic             hf_q,
    input logic             frc_q,
    input logic             lvl_q,
    input logic             fall_q
);
    a_r8_los_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !link_up |=> (los_o || (frc_q && !lvl_q)));

    a_r8_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !link_up |=> !in_ready);

    a_r4_one_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && one_q) |=> !in_ready);

    a_r7_bad_high: assert property (@(posedge clk) disable iff (!rst_n)
        panel_err |-> (bus0_rgb == '1 && bus1_rgb == '1 && sclk_o && los_o && !in_ready));

    a_r3_first_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !one_q && !hf_q && link_up)
        |=> ($stable(bus0_rgb) && $stable(bus1_rgb)));

    a_r5_launch_level: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && one_q && link_up) |=> (sclk_o == fall_q));

    a_r10_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        link_up |=> ($stable(panel_err) && $stable(frc_q)));
endmodule

bind pxo_out pxo_out_chk u_chk (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .in_valid(in_valid),
    .in_ready(in_ready), .bus0_rgb(bus0_rgb), .bus1_rgb(bus1_rgb),
    .sclk_o(sclk_o), .los_o(los_o), .panel_err(panel_err),
    .one_q(one_q), .hf_q(hf_q), .frc_q(frc_q), .lvl_q(lvl_q), .fall_q(fall_q)
);

// File: tb/pxo_out_test.sv
`timescale 1ns/1ps
module pxo_out_test;
    logic        clk = 1'b0;
    logic        rst_n, link_up, cfg_one_pix, in_valid, in_hs, in_vs;
    logic [1:0]  cfg_panel, cfg_test;
    logic [17:0] in_rgb;
    logic [3:0]  in_ctl;
    logic        in_ready, sclk_o, hs_o, vs_o, los_o, panel_err;
    logic [17:0] bus0_rgb, bus1_rgb;
    logic [3:0]  ctl_o;

    int errors = 0;
    int checks = 0;
    int idx    = 0;
    logic [17:0] m_b0 = '0;

    always #2.5 clk = ~clk;

    pxo_out uut (
        .clk(clk), .rst_n(rst_n), .link_up(link_up), .cfg_one_pix(cfg_one_pix),
        .cfg_panel(cfg_panel), .cfg_test(cfg_test), .in_valid(in_valid),
        .in_ready(in_ready), .in_rgb(in_rgb), .in_hs(in_hs), .in_vs(in_vs),
        .in_ctl(in_ctl), .sclk_o(sclk_o), .bus0_rgb(bus0_rgb), .bus1_rgb(bus1_rgb),
        .hs_o(hs_o), .vs_o(vs_o), .ctl_o(ctl_o), .los_o(los_o), .panel_err(panel_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int period(input bit one, input int pnl);
        int base;
        base = (pnl == 0) ? 8 : (pnl == 1) ? 5 : 3;
        return one ? base : 2 * base;
    endfunction

    // pixel i: colour arithmetic, hs=i[0], vs=i[1], ctl=i[5:2]
    function automatic logic [23:0] gen(input int i);
        logic [17:0] c;
        c = 18'(i * 2741 + 12345);
        return {c, i[0], i[1], i[5:2]};
    endfunction

    task automatic setup(input bit one, input logic [1:0] pnl, input logic [1:0] tst);
        @(negedge clk);
        link_up     = 1'b0;
        cfg_one_pix = one;
        cfg_panel   = pnl;
        cfg_test    = tst;
        @(negedge clk);
        check(in_ready == 1'b0, "R8", "ready while link down", in_ready, 0);
        if (tst[1] == 1'b0 && pnl != 2'b11)
            check(los_o == 1'b1, "R8", "los while link down", los_o, 1);
        link_up = 1'b1;
        @(negedge clk);
    endtask

    task automatic push(input logic [23:0] p);
        in_valid = 1'b1;
        {in_rgb, in_hs, in_vs, in_ctl} = p;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic check_word(input logic [17:0] e0, input logic [17:0] e1,
                              input logic [5:0] es, input bit one, input int per,
                              input bit fall, input string req);
        check(bus0_rgb == e0, req, "bus0", bus0_rgb, e0);
        check(bus1_rgb == e1, req, "bus1", bus1_rgb, e1);
        check({hs_o, vs_o, ctl_o} == es, req, "sync/ctl", {hs_o, vs_o, ctl_o}, es);
        check(sclk_o == fall, "R5", "launch level", sclk_o, fall);
        for (int k = 1; k < per; k++) begin
            @(negedge clk);
            check(sclk_o == ((k < per / 2) ? fall : !fall), "R5", "shift clock phase",
                  sclk_o, (k < per / 2) ? fall : !fall);
            if (one)
                check(in_ready == (k == per - 1), "R4", "ready spacing", in_ready, k == per - 1);
        end
    endtask

    task automatic check_forced(input bit lvl, input string req);
        check(sclk_o == lvl && hs_o == lvl && vs_o == lvl && los_o == lvl, req,
              "forced sclk/sync/los", {sclk_o, hs_o, vs_o, los_o}, {4{lvl}});
        check(bus0_rgb == {18{lvl}} && bus1_rgb == {18{lvl}} && ctl_o == {4{lvl}}, req,
              "forced buses", bus1_rgb, {18{lvl}});
        check(in_ready == 1'b0, req, "ready while forced", in_ready, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL all watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [23:0] a, b, c;
        rst_n = 1'b0; link_up = 1'b1; cfg_one_pix = 1'b1; cfg_panel = 2'b00;
        cfg_test = 2'b00; in_valid = 1'b0; in_rgb = '0; in_hs = 0; in_vs = 0; in_ctl = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(los_o == 1'b1, "R1", "los in reset", los_o, 1);
        check(in_ready == 1'b0, "R1", "ready in reset", in_ready, 0);
        check(bus1_rgb == '0, "R1", "bus1 in reset", bus1_rgb, 0);
        check(sclk_o == 1'b1, "R1", "sclk idle", sclk_o, 1);
        check(bus0_rgb == '1, "R2", "bus0 one-pixel", bus0_rgb, 18'h3ffff);
        rst_n = 1'b1;
        @(negedge clk);
        check(los_o == 1'b0, "R8", "los after link up", los_o, 0);
        check(panel_err == 1'b0, "R7", "panel_err clear", panel_err, 0);

        // sweep both packing modes, three panels, two polarities
        for (int one = 1; one >= 0; one--) begin
            for (int pnl = 0; pnl < 3; pnl++) begin
                for (int tst = 0; tst < 2; tst++) begin
                    setup(one[0], pnl[1:0], tst[1:0]);
                    for (int w = 0; w < 4; w++) begin
                        if (one != 0) begin
                            a = gen(idx++);
                            push(a);
                            check_word(18'h3ffff, a[23:6], a[5:0], 1'b1,
                                       period(1'b1, pnl), tst[0], "R2");
                        end else begin
                            a = gen(idx++);
                            b = gen(idx++);
                            c = {bus1_rgb, hs_o, vs_o, ctl_o};
                            push(a);
                            check({bus0_rgb, bus1_rgb} == {m_b0, c[23:6]}, "R3",
                                  "first pixel holds", bus1_rgb, c[23:6]);
                            push(b);
                            m_b0 = a[23:6];
                            check_word(a[23:6], b[23:6], a[5:0], 1'b0,
                                       period(1'b0, pnl), tst[0], "R3");
                        end
                    end
                end
            end
        end

        // R6 force levels
        setup(1'b1, 2'b00, 2'b10);
        check_forced(1'b0, "R6");
        check(panel_err == 1'b0, "R6", "panel_err not forced", panel_err, 0);
        setup(1'b1, 2'b00, 2'b11);
        check_forced(1'b1, "R6");

        // R7 unsupported panel, even with force-low strap
        setup(1'b0, 2'b11, 2'b00);
        check(panel_err == 1'b1, "R7", "panel_err set", panel_err, 1);
        check_forced(1'b1, "R7");
        setup(1'b0, 2'b11, 2'b10);
        check_forced(1'b1, "R7");

        // R9 link drop discards a pending first pixel
        setup(1'b0, 2'b01, 2'b00);
        check(panel_err == 1'b0, "R7", "panel_err cleared", panel_err, 0);
        a = gen(idx++);
        push(a);
        link_up = 1'b0;
        @(negedge clk);
        check(los_o == 1'b1, "R8", "los on drop", los_o, 1);
        link_up = 1'b1;
        @(negedge clk);
        b = gen(idx++);
        c = gen(idx++);
        push(b);
        push(c);
        check_word(b[23:6], c[23:6], b[5:0], 1'b0, period(1'b0, 1), 1'b0, "R9");

        // R10 configuration changes while link is up are ignored
        setup(1'b1, 2'b10, 2'b00);
        cfg_one_pix = 1'b0; cfg_test = 2'b11; cfg_panel = 2'b11;
        repeat (2) @(negedge clk);
        check(panel_err == 1'b0, "R10", "panel_err unchanged", panel_err, 0);
        check(sclk_o == 1'b1, "R10", "no force", sclk_o, 1);
        a = gen(idx++);
        push(a);
        check_word(18'h3ffff, a[23:6], a[5:0], 1'b1, period(1'b1, 2), 1'b0, "R10");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule